// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Full Flag Byte

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor datapath. Each evaluation takes an operation code, two operand bytes and the current flag byte. From these it produces a result byte, a new flag byte and a strobe that says whether the result should be written back to the destination register.

The flag byte uses the classic accumulator-machine layout. It includes the two otherwise unused bits, 3 and 5, which copy bits of a chosen byte. The operations are addition and subtraction with and without carry-in, compare, negate, the three bitwise operations, and increment and decrement of the first operand.

Each operation family follows its own rule for which flags it recomputes and which it passes through. Instruction decode, register storage and memory access belong to the surrounding datapath.

Top module: `alu8_core`

## Requirements
- R1: The flag byte layout is bit 7 sign, bit 6 zero, bit 5 copy of a source bit 5, bit 4 half-carry, bit 3 copy of a source bit 3, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Unless another requirement says otherwise, sign, zero, bit 5 and bit 3 come from the result byte.
- R2: Operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 negate, 6 AND, 7 OR, 8 XOR, 9 increment, 10 decrement. Codes 11 to 15 leave the flags equal to flags_in, give result equal to opnd_a and hold result_we low.
- R3: Add and add-with-carry give (a+b+cin) mod 256. Carry is bit 8 of the 9-bit sum. Half-carry is the carry out of bit 3. Parity/overflow holds signed two's-complement overflow. Subtract is 0.
- R4: Subtract and subtract-with-borrow give (a-b-cin) mod 256. Carry is the borrow out of bit 7. Half-carry is the borrow out of bit 3. Parity/overflow holds signed overflow. Subtract is 1.
- R5: Compare sets the flags as a subtract of b from a, with two exceptions: bits 5 and 3 come from opnd_b, and zero is set only when no borrow occurs and the difference is zero. The result port shows opnd_a unchanged and result_we is 0.
- R6: Negate gives exactly the result and flags of subtracting opnd_a from zero.
- R7: AND sets half-carry to 1, and OR and XOR clear it. For all three, parity/overflow is 1 when the result has an even number of ones, and carry and subtract are 0.
- R8: Increment gives opnd_a+1 mod 256 and leaves carry equal to flags_in bit 0. Overflow is set when the result is 0x80 and half-carry when the result's low nibble is 0. Subtract is 0.
- R9: Decrement gives opnd_a-1 mod 256 and leaves carry equal to flags_in bit 0. Half-carry is set when opnd_a's low nibble was 0 and overflow when the result is 0x7F. Subtract is 1.
- R10: Add-with-carry and subtract-with-borrow use flags_in bit 0 as carry-in. Add, subtract, compare and negate ignore it.
- R11: result_we is 1 for every valid operation code except compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, encoding per R2 |
| opnd_a | input | 8 | Accumulator / first operand |
| opnd_b | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| result_we | output | 1 | Write strobe for result |

## Verification
Several rules are checked on every evaluation: the write strobe per operation code, carry pass-through on increment and decrement, cleared carry on the bitwise operations, the subtract flag per family, the zero flag against the result, parity on the bitwise operations, and flag pass-through on unused codes. The numeric correctness of sums, differences, half-carry and overflow can only be shown by the bench. Its scenarios sweep every first operand against a spread of second operands with both carry-in values. This is also where the compare-specific bit 3/5 source and the negate equivalence are shown.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    parameter int unsigned DATA_W = 8;
    localparam int unsigned OP_W  = 4;
    localparam int unsigned NIB_W = DATA_W / 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_NEG = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd10;

    // packed order gives the flag byte bit positions directly
    typedef struct packed {
        logic s;
        logic z;
        logic x5;
        logic h;
        logic x3;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic op_is_valid(input logic [OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

    function automatic logic op_is_sub(input logic [OP_W-1:0] op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG);
    endfunction

    function automatic logic op_is_arith(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_ADC) || op_is_sub(op);
    endfunction

    function automatic logic op_is_logic(input logic [OP_W-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    // sign, zero and the two copied bits for a given result and copy source
    function automatic flags_t base_flags(input logic [DATA_W-1:0] res,
                                          input logic [DATA_W-1:0] copy_src);
        flags_t f;
        f    = '0;
        f.s  = res[DATA_W-1];
        f.z  = (res == '0);
        f.x5 = copy_src[5];
        f.x3 = copy_src[3];
        return f;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned HB = W / 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half,
    output logic         ovf
);
    localparam int unsigned HI_W = W - HB;

    logic [W-1:0]    y_eff;
    logic            c_eff;
    logic [HB:0]     lo_sum;
    logic [HI_W:0]   hi_sum;

    // subtraction is x + ~y + ~borrow; carries are inverted back to borrows
    always_comb begin
        y_eff  = sub ? ~y : y;
        c_eff  = cin ^ sub;
        lo_sum = {1'b0, x[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
        hi_sum = {1'b0, x[W-1:HB]} + {1'b0, y_eff[W-1:HB]} + {{HI_W{1'b0}}, lo_sum[HB]};
        sum    = {hi_sum[HI_W-1:0], lo_sum[HB-1:0]};
        cout   = hi_sum[HI_W] ^ sub;
        half   = lo_sum[HB] ^ sub;
        ovf    = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res,
    output logic         half
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            default: res = a ^ b;
        endcase
        half = (sel == LG_AND);
    end

endmodule

// File: rtl/alu8_step.sv
module alu8_step
    import alu8_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned HB = W / 2
) (
    input  logic [W-1:0] a,
    input  logic         down,
    output logic [W-1:0] res,
    output logic         half,
    output logic         ovf
);
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (down) begin
            res  = a - 1'b1;
            half = (a[HB-1:0] == '0);
            ovf  = (res == MAX_POS);
        end else begin
            res  = a + 1'b1;
            half = (res[HB-1:0] == '0);
            ovf  = (res == MSB_ONLY);
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic [7:0] flags_in,
    output logic [7:0] result,
    output logic [7:0] flags_out,
    output logic       result_we
);
    logic [DATA_W-1:0] ar_x, ar_y, ar_sum;
    logic              ar_cin, ar_sub, ar_cout, ar_half, ar_ovf;
    logic [DATA_W-1:0] lg_res;
    logic              lg_half;
    logic_sel_e        lg_sel;
    logic [DATA_W-1:0] st_res;
    logic              st_half, st_ovf, st_down;
    flags_t            fin, fnew;

    assign fin = flags_t'(flags_in);

    // operand steering for the add/subtract engine
    always_comb begin
        ar_sub = op_is_sub(op_code);
        ar_x   = (op_code == OP_NEG) ? '0 : opnd_a;
        ar_y   = (op_code == OP_NEG) ? opnd_a : opnd_b;
        ar_cin = ((op_code == OP_ADC) || (op_code == OP_SBC)) ? fin.c : 1'b0;
    end

    always_comb begin
        unique case (op_code)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            default: lg_sel = LG_XOR;
        endcase
    end

    assign st_down = (op_code == OP_DEC);

    alu8_arith #(.W(DATA_W)) u_arith (
        .x    (ar_x),
        .y    (ar_y),
        .cin  (ar_cin),
        .sub  (ar_sub),
        .sum  (ar_sum),
        .cout (ar_cout),
        .half (ar_half),
        .ovf  (ar_ovf)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a    (opnd_a),
        .b    (opnd_b),
        .sel  (lg_sel),
        .res  (lg_res),
        .half (lg_half)
    );

    alu8_step #(.W(DATA_W)) u_step (
        .a    (opnd_a),
        .down (st_down),
        .res  (st_res),
        .half (st_half),
        .ovf  (st_ovf)
    );

    // result and flag assembly per operation family
    always_comb begin
        result    = opnd_a;
        fnew      = fin;
        result_we = 1'b0;
        if (op_is_arith(op_code)) begin
            fnew    = base_flags(ar_sum, (op_code == OP_CMP) ? opnd_b : ar_sum);
            fnew.h  = ar_half;
            fnew.pv = ar_ovf;
            fnew.n  = ar_sub;
            fnew.c  = ar_cout;
            if (op_code == OP_CMP) begin
                fnew.z = ~ar_cout && (ar_sum == '0);
            end else begin
                result    = ar_sum;
                result_we = 1'b1;
            end
        end else if (op_is_logic(op_code)) begin
            fnew      = base_flags(lg_res, lg_res);
            fnew.h    = lg_half;
            fnew.pv   = even_parity(lg_res);
            fnew.n    = 1'b0;
            fnew.c    = 1'b0;
            result    = lg_res;
            result_we = 1'b1;
        end else if ((op_code == OP_INC) || (op_code == OP_DEC)) begin
            fnew      = base_flags(st_res, st_res);
            fnew.h    = st_half;
            fnew.pv   = st_ovf;
            fnew.n    = st_down;
            fnew.c    = fin.c;
            result    = st_res;
            result_we = 1'b1;
        end
    end

    assign flags_out = fnew;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic [3:0] op_code,
    input logic [7:0] opnd_a,
    input logic [7:0] opnd_b,
    input logic [7:0] flags_in,
    input logic [7:0] result,
    input logic [7:0] flags_out,
    input logic       result_we
);
    logic known;
    assign known = !$isunknown({op_code, opnd_a, opnd_b, flags_in});

    always_comb begin
        if (known) begin
            assert_we_rule_R11: assert (result_we == (op_is_valid(op_code) && (op_code != OP_CMP)))
                else $error("write strobe wrong for op %0d", op_code);
            if (!op_is_valid(op_code)) begin
                assert_unused_passthru_R2: assert ((flags_out == flags_in) && (result == opnd_a))
                    else $error("unused op altered outputs");
            end
            if (op_code == OP_CMP) begin
                assert_cmp_keeps_acc_R5: assert (result == opnd_a)
                    else $error("compare changed result");
                assert_cmp_copy_bits_R5: assert ((flags_out[5] == opnd_b[5]) && (flags_out[3] == opnd_b[3]))
                    else $error("compare bits 5/3 not from operand");
            end
            if ((op_code == OP_INC) || (op_code == OP_DEC)) begin
                assert_step_keeps_carry_R8: assert (flags_out[0] == flags_in[0])
                    else $error("inc/dec changed carry");
                assert_step_nflag_R9: assert (flags_out[1] == (op_code == OP_DEC))
                    else $error("inc/dec subtract flag");
            end
            if (op_is_logic(op_code)) begin
                assert_logic_cn_clear_R7: assert (flags_out[1:0] == 2'b00)
                    else $error("logic op carry/subtract not clear");
                assert_logic_parity_R7: assert (flags_out[2] == ~(^result))
                    else $error("logic op parity");
            end
            if (op_is_arith(op_code)) begin
                assert_arith_nflag_R4: assert (flags_out[1] == op_is_sub(op_code))
                    else $error("arith subtract flag");
            end
            if (op_is_valid(op_code) && (op_code != OP_CMP)) begin
                assert_zero_matches_R1: assert (flags_out[6] == (result == 8'h00))
                    else $error("zero flag mismatch");
                assert_sign_matches_R1: assert (flags_out[7] == result[7])
                    else $error("sign flag mismatch");
            end
        end
    end

endmodule

bind alu8_core alu8_core_chk u_chk (
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .result_we (result_we)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    typedef struct {
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] fi;
        logic [7:0] res;
        logic [7:0] fl;
        logic       we;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_a = 8'd0, opnd_b = 8'd0, flags_in = 8'd0;
    logic [7:0] result, flags_out;
    logic       result_we;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    alu8_core u_dut (
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .result_we (result_we)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4:       return "R5";
            4'd5:       return "R6";
            4'd6, 4'd7, 4'd8: return "R7";
            4'd9:       return "R8";
            4'd10:      return "R9";
            default:    return "R2";
        endcase
    endfunction

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // reference model from the requirements using integer arithmetic
    function automatic item_t model(input logic [3:0] op, input int a, input int b, input int fi);
        item_t t;
        int x, y, c, full, nib, sv, r, cy, hc, ov, pv, nf, cp;
        t.op = op; t.a = a[7:0]; t.b = b[7:0]; t.fi = fi[7:0];
        cp = -1;
        if (op <= 4'd5) begin
            x = (op == 4'd5) ? 0 : a;
            y = (op == 4'd5) ? a : b;
            c = (op == 4'd1 || op == 4'd3) ? (fi & 1) : 0;  // R10
            if (op <= 4'd1) begin
                full = x + y + c; nib = (x & 15) + (y & 15) + c; sv = sgn(x) + sgn(y) + c;
                cy = (full > 255); hc = (nib > 15); nf = 0;
            end else begin
                full = x - y - c; nib = (x & 15) - (y & 15) - c; sv = sgn(x) - sgn(y) - c;
                cy = (full < 0); hc = (nib < 0); nf = 1;
            end
            ov = (sv > 127 || sv < -128);
            r = full & 255;
            pv = ov;
            if (op == 4'd4) cp = b;
        end else if (op <= 4'd8) begin
            r = (op == 4'd6) ? (a & b) : (op == 4'd7) ? (a | b) : (a ^ b);
            hc = (op == 4'd6); pv = (ones(r) % 2 == 0); cy = 0; nf = 0;
        end else if (op == 4'd9) begin
            r = (a + 1) & 255; hc = ((r & 15) == 0); pv = (r == 128); cy = fi & 1; nf = 0;
        end else if (op == 4'd10) begin
            r = (a + 255) & 255; hc = ((a & 15) == 0); pv = (r == 127); cy = fi & 1; nf = 1;
        end else begin
            t.res = a[7:0]; t.fl = fi[7:0]; t.we = 1'b0;
            return t;
        end
        if (cp < 0) cp = r;
        t.fl = 8'((r & 128) | ((r == 0 && !(op == 4'd4 && cy)) ? 64 : 0) | (cp & 32) |
                  (hc ? 16 : 0) | (cp & 8) | (pv ? 4 : 0) | (nf ? 2 : 0) | (cy ? 1 : 0));
        t.res = (op == 4'd4) ? a[7:0] : r[7:0];
        t.we  = (op != 4'd4);
        return t;
    endfunction

    task automatic drive(input logic [3:0] op, input int a, input int b, input int fi);
        @(posedge clk);
        op_code  = op;
        opnd_a   = a[7:0];
        opnd_b   = b[7:0];
        flags_in = fi[7:0];
        sb_q.push_back(model(op, a, b, fi));
    endtask

    // monitor: compare half a period after each drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t e;
                e = sb_q.pop_front();
                checks++;
                if (result !== e.res || flags_out !== e.fl || result_we !== e.we) begin
                    fails++;
                    if (fails <= 20)
                        $display("FAIL %s op=%0d a=%02h b=%02h fi=%02h : got res=%02h fl=%02h we=%0b exp res=%02h fl=%02h we=%0b",
                                 req_of(e.op), e.op, e.a, e.b, e.fi, result, flags_out, result_we,
                                 e.res, e.fl, e.we);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset-time state: add of zeros gives only the zero flag (R1)
        drive(4'd0, 0, 0, 0);
        // corner cases
        drive(4'd0, 8'h7F, 8'h01, 0);      // R3 overflow, half
        drive(4'd1, 8'hFF, 8'h00, 1);      // R10 carry in on ADC
        drive(4'd0, 8'hFF, 8'h00, 1);      // R10 ADD ignores carry
        drive(4'd2, 8'h80, 8'h01, 1);      // R4 overflow, R10 ignored
        drive(4'd3, 8'h00, 8'h00, 1);      // R4 borrow through
        drive(4'd4, 8'h10, 8'h10, 0);      // R5 equal
        drive(4'd4, 8'h00, 8'h28, 0);      // R5 bits 5/3 from operand
        drive(4'd5, 8'h80, 0, 0);          // R6 negate 0x80
        drive(4'd5, 8'h00, 0, 0);          // R6 negate zero
        drive(4'd9, 8'h7F, 0, 1);          // R8 0x80 overflow, carry kept
        drive(4'd9, 8'hFF, 0, 0);          // R8 wrap
        drive(4'd10, 8'h80, 0, 1);         // R9 0x7F overflow
        drive(4'd10, 8'h00, 0, 0);         // R9 wrap
        drive(4'd6, 8'hF0, 8'h0F, 0);      // R7 AND zero
        for (int op = 11; op < 16; op++)   // R2 unused codes
            for (int k = 0; k < 16; k++)
                drive(4'(op), k * 17, k * 5, k * 29);
        // sweep: every a, b spread, both carry values (R11 checked by we field)
        for (int op = 0; op <= 10; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    for (int c = 0; c < 2; c++)
                        drive(4'(op), a, (bi * 17 + a) & 255, ((a ^ (bi * 23)) & 8'hFE) | c);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule